// File: doc/BRIEF.md
# Compare and Sync Pulse Generator

This block watches a free-running 64-bit timebase supplied from outside and compares it against a bank of programmable compare values. When the count crosses an enabled compare value, a sticky status flag for that channel is raised. Channel 0 can also request a reset of the external counter. This gives cycle-time operation, where the timebase wraps at a programmed value. Software clears the flags by writing ones.

Channel 1 launches a pulse on the sync0 pin. The pulse stays high for a programmed number of clock cycles. A repeat interval can make it recur, or an interval of zero gives a single pulse per match. A shadow option stages new compare values while the current cycle runs and applies them only when the channel 0 reset fires. Software can therefore retune the cycle without the risk of a half-updated compare value.

Top module: `cmp_sync_gen`

## Requirements
- R1: After reset, every register reads 0, and both `sync0_o` and `cnt_reset_o` are low.
- R2: When configuration bit n+1 is set, channel n sets status bit n. The flag is set one cycle after a cycle in which `cnt_i` is at or above the channel's compare value while the previous cycle's count was below it. A channel whose enable bit is clear never sets its flag, and a count that starts above the value does not set it.
- R3: Status flags stay set until software writes 1 to that bit at word 0x01. If a match and a clear of the same bit fall in the same cycle, the flag stays set.
- R4: When configuration bit 0 is set and channel 0 is enabled, `cnt_reset_o` is high exactly in the cycle where channel 0 matches. Otherwise it stays low.
- R5: Compare value n is 64 bits wide. Its low word is at word 0x10+2n and its high word at 0x11+2n, and both read back as written.
- R6: When configuration bit 17 is set, compare writes read back at once, but they take effect only at the next `cnt_reset_o` cycle. Until then the previous value keeps matching.
- R7: The sync control word at 0x02 needs both bit 0 (master enable) and bit 1 (pin enable) set. With both set, a channel 1 match drives `sync0_o` high from the next cycle for the number of cycles held in word 0x03.
- R8: With the interval word at 0x04 equal to 0, a channel 1 match gives exactly one pulse.
- R9: A non-zero interval P makes the pulse restart every P cycles after the match.
- R10: Writing a sync control value without both bits set drives `sync0_o` low in the next cycle and cancels any repetition. While the control value is not 3, channel 1 matches raise no pulse.
- R11: A count that steps past a compare value without ever equalling it still counts as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| cnt_i | input | 64 | Current timebase value |
| cnt_reset_o | output | 1 | Request to clear the timebase this cycle |
| sync0_o | output | 1 | Sync pulse output |

## Verification
Two collisions are provoked. In the first, a status clear write lands in the same cycle that the channel crosses its value. The bench polls its own counter model and issues the write-one-to-clear exactly in the crossing cycle, then expects the flag to read back set. In the second, a shadowed compare write is pending when the channel 0 reset fires. The bench records the counter value at each reset and expects the old cycle length once, then the new one.

// File: rtl/cmp_sync_pkg.sv
package cmp_sync_pkg;
    localparam int MAX_CMP = 16;
    localparam int ADDR_W  = 6;

    localparam logic [ADDR_W-1:0] A_CFG     = 6'h00;
    localparam logic [ADDR_W-1:0] A_STAT    = 6'h01;
    localparam logic [ADDR_W-1:0] A_SCTRL   = 6'h02;
    localparam logic [ADDR_W-1:0] A_SWIDTH  = 6'h03;
    localparam logic [ADDR_W-1:0] A_SPERIOD = 6'h04;
    localparam logic [ADDR_W-1:0] A_CMPBASE = 6'h10;

    // Packed so that bit 0 is the reset enable, bits 16:1 the channel enables, bit 17 shadow
    typedef struct packed {
        logic               shadow;
        logic [MAX_CMP-1:0] ch_en;
        logic               rst_on_c0;
    } cmp_cfg_t;

    typedef struct packed {
        logic out0_en;
        logic glob_en;
    } sync_ctrl_t;

    function automatic logic [ADDR_W-1:0] cmp_word_addr(input int ch, input logic hi);
        return A_CMPBASE + ADDR_W'(2 * ch) + ADDR_W'(hi);
    endfunction
endpackage

// File: rtl/cmp_sync_chan.sv
module cmp_sync_chan
    import cmp_sync_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32,
    parameter int CH     = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_i,
    input  logic              shadow_i,
    input  logic              load_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  prev_i,
    output logic              match_o,
    output logic [CNT_W-1:0]  prog_o,
    output logic [CNT_W-1:0]  act_o
);
    localparam logic [ADDR_W-1:0] A_LO = cmp_word_addr(CH, 1'b0);
    localparam logic [ADDR_W-1:0] A_HI = cmp_word_addr(CH, 1'b1);

    logic [CNT_W-1:0] prog_q, act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prog_q <= '0;
            act_q  <= '0;
        end else begin
            if (load_i)
                act_q <= prog_q;
            if (wr_i && addr_i == A_LO) begin
                prog_q[DATA_W-1:0] <= wdata_i;
                if (!shadow_i)
                    act_q[DATA_W-1:0] <= wdata_i;
            end
            if (wr_i && addr_i == A_HI) begin
                prog_q[CNT_W-1:DATA_W] <= wdata_i;
                if (!shadow_i)
                    act_q[CNT_W-1:DATA_W] <= wdata_i;
            end
        end
    end

    // Crossing detection: reached now, not reached in the previous cycle
    assign match_o = en_i && (cnt_i >= act_q) && (prev_i < act_q);
    assign prog_o  = prog_q;
    assign act_o   = act_q;
endmodule

// File: rtl/cmp_sync_pulse.sv
module cmp_sync_pulse #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              kill_i,
    input  logic              trigger_i,
    input  logic [DATA_W-1:0] width_i,
    input  logic [DATA_W-1:0] period_i,
    output logic              pulse_o
);
    logic [DATA_W-1:0] hi_left_q, per_left_q;
    logic              repeat_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || kill_i) begin
            hi_left_q  <= '0;
            per_left_q <= '0;
            repeat_q   <= 1'b0;
        end else if (trigger_i) begin
            hi_left_q  <= width_i;
            per_left_q <= period_i;
            repeat_q   <= (period_i != '0);
        end else begin
            if (hi_left_q != '0)
                hi_left_q <= hi_left_q - 1'b1;
            if (repeat_q) begin
                if (per_left_q <= DATA_W'(1)) begin
                    hi_left_q  <= width_i;
                    per_left_q <= period_i;
                end else begin
                    per_left_q <= per_left_q - 1'b1;
                end
            end
        end
    end

    assign pulse_o = (hi_left_q != '0);
endmodule

// File: rtl/cmp_sync_gen.sv
module cmp_sync_gen
    import cmp_sync_pkg::*;
#(
    parameter int NCMP   = 4,
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              cnt_reset_o,
    output logic              sync0_o
);
    localparam int CFG_W = $bits(cmp_cfg_t);
    localparam int SC_W  = $bits(sync_ctrl_t);

    cmp_cfg_t          cfg_q;
    sync_ctrl_t        sctrl_q;
    logic [NCMP-1:0]   stat_q, match_vec, clr_vec;
    logic [DATA_W-1:0] width_q, period_q;
    logic [CNT_W-1:0]  prev_q;
    logic [CNT_W-1:0]  prog_vec [NCMP];
    logic [CNT_W-1:0]  act_vec  [NCMP];
    logic              sync_run, sctrl_wr, pulse_kill, pulse_trig;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q    <= '0;
            sctrl_q  <= '0;
            stat_q   <= '0;
            width_q  <= '0;
            period_q <= '0;
            prev_q   <= '0;
        end else begin
            prev_q <= cnt_i;
            stat_q <= (stat_q & ~clr_vec) | match_vec;
            if (bus_wr_i) begin
                case (bus_addr_i)
                    A_CFG:     cfg_q    <= cmp_cfg_t'(bus_wdata_i[CFG_W-1:0]);
                    A_SCTRL:   sctrl_q  <= sync_ctrl_t'(bus_wdata_i[SC_W-1:0]);
                    A_SWIDTH:  width_q  <= bus_wdata_i;
                    A_SPERIOD: period_q <= bus_wdata_i;
                    default:   ;
                endcase
            end
        end
    end

    assign clr_vec = (bus_wr_i && bus_addr_i == A_STAT) ? bus_wdata_i[NCMP-1:0] : '0;

    generate
        for (genvar n = 0; n < NCMP; n++) begin : g_ch
            cmp_sync_chan #(
                .CNT_W (CNT_W),
                .DATA_W(DATA_W),
                .CH    (n)
            ) chan_i (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .en_i    (cfg_q.ch_en[n]),
                .shadow_i(cfg_q.shadow),
                .load_i  (cnt_reset_o),
                .wr_i    (bus_wr_i),
                .addr_i  (bus_addr_i),
                .wdata_i (bus_wdata_i),
                .cnt_i   (cnt_i),
                .prev_i  (prev_q),
                .match_o (match_vec[n]),
                .prog_o  (prog_vec[n]),
                .act_o   (act_vec[n])
            );
        end
    endgenerate

    assign cnt_reset_o = cfg_q.rst_on_c0 && match_vec[0];

    assign sync_run   = sctrl_q.glob_en && sctrl_q.out0_en;
    assign sctrl_wr   = bus_wr_i && bus_addr_i == A_SCTRL;
    assign pulse_kill = !sync_run || (sctrl_wr && !(bus_wdata_i[0] && bus_wdata_i[1]));
    assign pulse_trig = sync_run && match_vec[1];

    cmp_sync_pulse #(.DATA_W(DATA_W)) pulse_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .kill_i   (pulse_kill),
        .trigger_i(pulse_trig),
        .width_i  (width_q),
        .period_i (period_q),
        .pulse_o  (sync0_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_CFG:     bus_rdata_o = DATA_W'(cfg_q);
            A_STAT:    bus_rdata_o = DATA_W'(stat_q);
            A_SCTRL:   bus_rdata_o = DATA_W'(sctrl_q);
            A_SWIDTH:  bus_rdata_o = width_q;
            A_SPERIOD: bus_rdata_o = period_q;
            default:   ;
        endcase
        for (int n = 0; n < NCMP; n++) begin
            if (bus_addr_i == cmp_word_addr(n, 1'b0))
                bus_rdata_o = prog_vec[n][DATA_W-1:0];
            if (bus_addr_i == cmp_word_addr(n, 1'b1))
                bus_rdata_o = prog_vec[n][CNT_W-1:DATA_W];
        end
    end
endmodule

// File: rtl/cmp_sync_gen_chk.sv
module cmp_sync_gen_chk
    import cmp_sync_pkg::*;
#(
    parameter int NCMP   = 4,
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [NCMP-1:0]   stat_i,
    input logic              cnt_reset_i,
    input logic              sync0_i,
    input logic              shadow_i,
    input logic [CNT_W-1:0]  act0_i
);
    AST_RESET_FLAGS_CH0: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_reset_i |=> stat_i[0]); // R4

    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        !(wr_i && addr_i == A_STAT) |=> ((stat_i & $past(stat_i)) == $past(stat_i))); // R3

    AST_SYNC_STOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == A_SCTRL && !(wdata_i[0] && wdata_i[1])) |=> !sync0_i); // R10

    AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (shadow_i && !cnt_reset_i) |=> $stable(act0_i)); // R6
endmodule

bind cmp_sync_gen cmp_sync_gen_chk #(
    .NCMP  (NCMP),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .stat_i     (stat_q),
    .cnt_reset_i(cnt_reset_o),
    .sync0_i    (sync0_o),
    .shadow_i   (cfg_q.shadow),
    .act0_i     (act_vec[0])
);

// File: tb/cmp_sync_gen_tb_top.sv
module cmp_sync_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] cnt;
    logic        cnt_reset, sync0;

    logic        ld = 1'b0;
    logic [63:0] ld_val = '0;
    logic [63:0] step = '0;
    logic        rst_seen = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic smp [48];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_sync_gen dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .bus_wr_i   (bus_wr),
        .bus_addr_i (bus_addr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .cnt_i      (cnt),
        .cnt_reset_o(cnt_reset),
        .sync0_o    (sync0)
    );

    // Bench timebase model
    always @(negedge clk) rst_seen <= cnt_reset;
    always @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (ld)       cnt <= ld_val;
        else if (rst_seen) cnt <= '0;
        else               cnt <= cnt + step;
    end

    typedef struct packed {
        logic [1:0]  ch;
        logic [63:0] cv;
        logic [63:0] st;
        logic [63:0] sp;
        logic [7:0]  n;
        logic        en;
        logic        ex;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 64'd100, 64'd90, 64'd1, 8'd20, 1'b1, 1'b1},
        '{2'd2, 64'd100, 64'd90, 64'd7, 8'd5, 1'b1, 1'b1},
        '{2'd3, 64'h1_0000_0005, 64'hFFFF_FFF0, 64'd4, 8'd10, 1'b1, 1'b1},
        '{2'd1, 64'd100, 64'd90, 64'd1, 8'd20, 1'b0, 1'b0},
        '{2'd2, 64'd50, 64'd60, 64'd1, 8'd20, 1'b1, 1'b0},
        '{2'd1, 64'd100, 64'd90, 64'd20, 8'd3, 1'b1, 1'b1},
        '{2'd0, 64'd100, 64'd50, 64'd1, 8'd20, 1'b1, 1'b0},
        '{2'd3, 64'hFFFF_FFFF, 64'hFFFF_FF00, 64'h40, 8'd6, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_cnt(input logic [63:0] v, input logic [63:0] s);
        @(negedge clk);
        ld = 1'b1; ld_val = v; step = s;
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic wr_cmp(input int ch, input logic [63:0] v);
        wr(6'h10 + 6'(2 * ch), v[31:0]);
        wr(6'h11 + 6'(2 * ch), v[63:32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int nrst, nhi, nrise, f, bad;
        logic [63:0] first_cnt, rv0, rv1;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 sync0", 64'(sync0), 64'd0);
        chk("R1 cnt_reset", 64'(cnt_reset), 64'd0);
        rd(6'h00, r); chk("R1 cfg", 64'(r), 64'd0);
        rd(6'h01, r); chk("R1 stat", 64'(r), 64'd0);
        rd(6'h02, r); chk("R1 sctrl", 64'(r), 64'd0);
        rd(6'h03, r); chk("R1 width", 64'(r), 64'd0);
        rd(6'h04, r); chk("R1 period", 64'(r), 64'd0);
        rd(6'h10, r); chk("R1 cmp0", 64'(r), 64'd0);

        // R5 64-bit compare readback
        wr_cmp(2, 64'hDEAD_BEEF_1234_5678);
        rd(6'h14, r); chk("R5 low word", 64'(r), 64'h1234_5678);
        rd(6'h15, r); chk("R5 high word", 64'(r), 64'hDEAD_BEEF);

        // R2 / R11 table of crossing scenarios
        for (int i = 0; i < 8; i++) begin
            wr(6'h00, 32'd0);
            load_cnt(VEC[i].st, 64'd0);
            wr(6'h01, 32'hF);
            wr_cmp(int'(VEC[i].ch), VEC[i].cv);
            wr(6'h00, VEC[i].en ? (32'd1 << (VEC[i].ch + 1)) : 32'd0);
            @(negedge clk);
            step = VEC[i].sp;
            repeat (int'(VEC[i].n)) @(negedge clk);
            step = '0;
            wr(6'h00, 32'd0);
            rd(6'h01, r);
            chk($sformatf("R2 R11 vector %0d", i), 64'(r),
                VEC[i].ex ? (64'd1 << VEC[i].ch) : 64'd0);
        end

        // R3 set wins over same-cycle clear, then clear works
        wr(6'h00, 32'd0);
        load_cnt(64'd40, 64'd0);
        wr(6'h01, 32'hF);
        wr_cmp(3, 64'd50);
        wr(6'h00, 32'd1 << 4);
        @(negedge clk);
        step = 64'd1;
        while (cnt != 64'd50) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h01; bus_wdata = 32'h8;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(6'h01, r); chk("R3 set wins", 64'(r), 64'h8);
        wr(6'h01, 32'h8);
        rd(6'h01, r); chk("R3 w1c", 64'(r), 64'h0);
        wr(6'h00, 32'd0);

        // R4 cycle reset at compare 0
        load_cnt(64'd0, 64'd0);
        wr_cmp(0, 64'd15);
        wr(6'h00, 32'h3);
        @(negedge clk);
        step = 64'd1;
        nrst = 0; bad = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cnt_reset) begin
                nrst++;
                if (cnt != 64'd15) bad++;
            end
        end
        chk("R4 reset count>=2", 64'(nrst >= 2), 64'd1);
        chk("R4 reset at value", 64'(bad), 64'd0);
        wr(6'h00, 32'h2);
        load_cnt(64'd0, 64'd1);
        nrst = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (cnt_reset) nrst++;
        end
        chk("R4 no reset when disabled", 64'(nrst), 64'd0);
        wr(6'h00, 32'd0);

        // R6 shadowed compare update
        load_cnt(64'd0, 64'd0);
        wr_cmp(0, 64'd15);
        wr(6'h00, 32'h2_0003);
        wr_cmp(0, 64'd7);
        rd(6'h10, r); chk("R6 readback", 64'(r), 64'd7);
        @(negedge clk);
        step = 64'd1;
        nrst = 0; rv0 = '1; rv1 = '1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (cnt_reset) begin
                if (nrst == 0) rv0 = cnt;
                if (nrst == 1) rv1 = cnt;
                nrst++;
            end
        end
        chk("R6 old value first", rv0, 64'd15);
        chk("R6 new value after wrap", rv1, 64'd7);
        wr(6'h00, 32'd0);

        // R7 R8 one-shot pulse
        load_cnt(64'd0, 64'd0);
        wr_cmp(1, 64'd20);
        wr(6'h03, 32'd3);
        wr(6'h04, 32'd0);
        wr(6'h02, 32'd3);
        wr(6'h00, 32'd1 << 2);
        @(negedge clk);
        step = 64'd1;
        nhi = 0; nrise = 0; first_cnt = '1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sync0) begin
                if (nhi == 0) first_cnt = cnt;
                nhi++;
            end
            if (sync0 && i > 0 && !smp[0]) nrise++;
            smp[0] = sync0;
        end
        chk("R7 start cycle", first_cnt, 64'd21);
        chk("R7 width", 64'(nhi), 64'd3);
        chk("R8 single pulse", 64'(nrise), 64'd1);

        // R9 repeating pulse
        wr(6'h02, 32'd0);
        wr(6'h00, 32'd0);
        load_cnt(64'd0, 64'd0);
        wr(6'h03, 32'd2);
        wr(6'h04, 32'd8);
        wr(6'h02, 32'd3);
        wr(6'h00, 32'd1 << 2);
        @(negedge clk);
        step = 64'd1;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            smp[i] = sync0;
        end
        f = -1;
        for (int i = 47; i >= 0; i--) if (smp[i]) f = i;
        chk("R9 pulse seen", 64'(f >= 0 && f < 30), 64'd1);
        if (f >= 0 && f < 30) begin
            chk("R9 width", {62'd0, smp[f], smp[f+1]}, 64'h3);
            chk("R9 gap", 64'(smp[f+2]), 64'd0);
            chk("R9 second", {62'd0, smp[f+8], smp[f+9]}, 64'h3);
            chk("R9 third", {62'd0, smp[f+10], smp[f+16]}, 64'h1);
        end

        // R10 stop and ignore
        wr(6'h02, 32'd0);
        chk("R10 stop next cycle", 64'(sync0), 64'd0);
        nhi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sync0) nhi++;
        end
        chk("R10 stays stopped", 64'(nhi), 64'd0);
        wr(6'h00, 32'd0);
        load_cnt(64'd0, 64'd0);
        wr(6'h02, 32'd1);
        wr(6'h00, 32'd1 << 2);
        @(negedge clk);
        step = 64'd1;
        nhi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sync0) nhi++;
        end
        chk("R10 pin disabled", 64'(nhi), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule